// File: doc/BRIEF.md
# Porch-Programmed Display Timing Generator

This block generates the raster timing for a parallel RGB panel: horizontal and vertical sync, a data-enable strobe, and the zero-based pixel column and row of the pixel being shown. Each axis is described by four lengths: sync width, back porch, active size and front porch. Every length is supplied as its count minus one. Pixels advance on a pixel-clock enable derived from the source clock. The divider can run divided or be bypassed so that each pixel lasts a single source cycle.

All timing fields, the divider fields, the sync polarities and the video enable are captured into a working copy only at a frame boundary. A programming change made in the middle of a frame therefore never distorts the frame being scanned. Clearing the video enable lets the current frame run to its end before the outputs fall idle.

Each frame start coincides with the first cycle of vertical sync. When the global interrupt enable and the frame interrupt enable are both set at that moment, a pending flag is raised. A one-cycle clear pulse, meaning a write of 1, drops the flag.

Top module: `dtg_top`

## Requirements
- R1: After reset, hsync and vsync sit at their inactive level (low, because both polarities reset to active-high), de is 0, pix_x and pix_y are 0 and irq is 0.
- R2: A line is (h_sync_m1+1)+(h_back_m1+1)+(h_act_m1+1)+(h_front_m1+1) pixel periods long, in the order sync, back porch, active, front porch, and hsync is active during the sync part.
- R3: A frame is the sum of the four vertical fields, each plus one, in lines, in the same order, and vsync is active for all of the sync lines, starting with the first pixel of the frame.
- R4: de is 1 only when both axes are in their active part. pix_x and pix_y then give the zero-based column and row inside the active area. Both are 0 whenever de is 0.
- R5: hs_pol=1 makes hsync active-high and hs_pol=0 makes it active-low. vs_pol acts the same way on vsync.
- R6: With div_sel=1, each pixel period lasts div_m1+1 source cycles. With div_sel=0, each pixel period lasts exactly one source cycle whatever div_m1 holds.
- R7: A change to any timing, divider or polarity input in the middle of a frame has no effect until the next frame begins.
- R8: While idle, setting vid_en starts a frame on the following source cycle, at column 0 of line 0, with hsync and vsync both active.
- R9: Clearing vid_en in the middle of a frame lets that frame complete in full. The outputs then stay idle, with no sync active and de at 0, and no new frame starts.
- R10: irq rises at the first cycle of a frame when irq_glb_en and irq_frm_en were both 1 at the boundary. It stays 0 at a frame start if either enable is 0.
- R11: A one-cycle irq_clr pulse clears the pending flag on the next cycle, unless a frame start sets the flag in that same cycle, in which case the set wins. Without a clear pulse the flag holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vid_en | input | 1 | Video enable, sampled at frame boundaries |
| div_sel | input | 1 | 1 selects divided pixel clock, 0 selects 1:1 |
| div_m1 | input | DIV_W | Divide ratio minus one |
| hs_pol | input | 1 | 1 = hsync active-high |
| vs_pol | input | 1 | 1 = vsync active-high |
| h_sync_m1 | input | H_W | Horizontal sync width minus one |
| h_back_m1 | input | H_W | Horizontal back porch minus one |
| h_act_m1 | input | H_W | Active pixels per line minus one |
| h_front_m1 | input | H_W | Horizontal front porch minus one |
| v_sync_m1 | input | V_W | Vertical sync width (lines) minus one |
| v_back_m1 | input | V_W | Vertical back porch minus one |
| v_act_m1 | input | V_W | Active lines minus one |
| v_front_m1 | input | V_W | Vertical front porch minus one |
| irq_glb_en | input | 1 | Global interrupt enable |
| irq_frm_en | input | 1 | Frame interrupt enable |
| irq_clr | input | 1 | Write-1 pulse clearing the pending flag |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | H_W | Active column |
| pix_y | output | V_W | Active row |
| irq | output | 1 | Frame interrupt pending |

## Verification
The situations hardest to reach from the ports are a programming change that lands in the middle of a frame and a clear pulse that coincides with a frame start. Both depend on the input changing at an arbitrary cycle relative to a boundary that can lie hundreds of cycles away. The stimulus draws small random porch, size and divider values so that frames stay short. It then changes the configuration, the enable and the clear pulse at random cycles within each run. An arithmetic model compares hsync, vsync, de, pix_x, pix_y and irq on every cycle. Directed sequences pin down the start-up cycle, bypass with a nonzero divide field, a mid-frame divider change and a mid-frame stop.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

   typedef enum logic [1:0] {
      PH_SYNC  = 2'd0,
      PH_BACK  = 2'd1,
      PH_ACT   = 2'd2,
      PH_FRONT = 2'd3
   } dtg_phase_e;

   // Map an "in sync" condition to a pin level for a given polarity.
   function automatic logic drive_level(input logic active, input logic act_high);
      return active ? act_high : ~act_high;
   endfunction

endpackage

// File: rtl/dtg_axis.sv
module dtg_axis
   import dtg_pkg::*;
#(
   parameter int W = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           restart,
   input  logic           step,
   input  logic [W-1:0]   sw_m1,
   input  logic [W-1:0]   bp_m1,
   input  logic [W-1:0]   act_m1,
   input  logic [W-1:0]   fp_m1,
   output dtg_phase_e     phase,
   output logic [W-1:0]   cnt,
   output logic           at_end
);

   if (W < 2) begin : g_w_chk
      $error("dtg_axis: W must be at least 2");
   end

   logic [W-1:0] len_m1;
   logic         seg_last;
   dtg_phase_e   phase_nx;

   always_comb begin
      case (phase)
         PH_SYNC:  len_m1 = sw_m1;
         PH_BACK:  len_m1 = bp_m1;
         PH_ACT:   len_m1 = act_m1;
         default:  len_m1 = fp_m1;
      endcase
   end

   always_comb begin
      case (phase)
         PH_SYNC:  phase_nx = PH_BACK;
         PH_BACK:  phase_nx = PH_ACT;
         PH_ACT:   phase_nx = PH_FRONT;
         default:  phase_nx = PH_SYNC;
      endcase
   end

   assign seg_last = (cnt == len_m1);
   assign at_end   = seg_last && (phase == PH_FRONT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_SYNC;
         cnt   <= '0;
      end else if (restart) begin
         phase <= PH_SYNC;
         cnt   <= '0;
      end else if (step) begin
         if (seg_last) begin
            phase <= phase_nx;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dtg_pix_div.sv
module dtg_pix_div #(
   parameter int DIV_W   = 8,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic             div_sel,
   input  logic [DIV_W-1:0] div_m1,
   output logic             pix_ce
);

   if (DIV_W < 1 || DIV_W > 16) begin : g_w_chk
      $error("dtg_pix_div: DIV_W must lie in 1..16");
   end

   if (HAS_DIV) begin : g_div
      logic [DIV_W-1:0] cnt;
      logic [DIV_W-1:0] lim;

      assign lim    = div_sel ? div_m1 : '0;
      assign pix_ce = run && (cnt == lim);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (restart || !run || pix_ce) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end else begin : g_bypass
      logic unused_div;
      assign unused_div = ^{clk, rst_n, restart, div_sel, div_m1};
      assign pix_ce     = run;
   end

endmodule

// File: rtl/dtg_irq.sv
module dtg_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pend
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (set) begin
         pend <= 1'b1;
      end else if (clr) begin
         pend <= 1'b0;
      end
   end

endmodule

// File: rtl/dtg_top.sv
module dtg_top
   import dtg_pkg::*;
#(
   parameter int H_W     = 12,
   parameter int V_W     = 11,
   parameter int DIV_W   = 8,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic             clk_src,
   input  logic             rst_n,
   input  logic             vid_en,
   input  logic             div_sel,
   input  logic [DIV_W-1:0] div_m1,
   input  logic             hs_pol,
   input  logic             vs_pol,
   input  logic [H_W-1:0]   h_sync_m1,
   input  logic [H_W-1:0]   h_back_m1,
   input  logic [H_W-1:0]   h_act_m1,
   input  logic [H_W-1:0]   h_front_m1,
   input  logic [V_W-1:0]   v_sync_m1,
   input  logic [V_W-1:0]   v_back_m1,
   input  logic [V_W-1:0]   v_act_m1,
   input  logic [V_W-1:0]   v_front_m1,
   input  logic             irq_glb_en,
   input  logic             irq_frm_en,
   input  logic             irq_clr,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic [H_W-1:0]   pix_x,
   output logic [V_W-1:0]   pix_y,
   output logic             irq
);

   if (H_W < 2 || V_W < 2) begin : g_w_chk
      $error("dtg_top: axis widths must be at least 2");
   end

   typedef struct packed {
      logic             div_sel;
      logic [DIV_W-1:0] div_m1;
      logic             hs_pol;
      logic             vs_pol;
      logic [H_W-1:0]   hsw;
      logic [H_W-1:0]   hbp;
      logic [H_W-1:0]   hact;
      logic [H_W-1:0]   hfp;
      logic [V_W-1:0]   vsw;
      logic [V_W-1:0]   vbp;
      logic [V_W-1:0]   vact;
      logic [V_W-1:0]   vfp;
   } tcfg_t;

   tcfg_t        live_cfg;
   tcfg_t        act_cfg;
   logic         running;
   logic         pix_ce;
   dtg_phase_e   h_phase;
   dtg_phase_e   v_phase;
   logic [H_W-1:0] h_cnt;
   logic [V_W-1:0] v_cnt;
   logic         h_end;
   logic         v_end;
   logic         frm_last;
   logic         bnd;
   logic         frm_ev;
   logic         h_step;
   logic         v_step;
   logic         in_act;
   logic         irq_set;
   logic         act_hs_pol;
   logic         act_vs_pol;

   always_comb begin
      live_cfg.div_sel = div_sel;
      live_cfg.div_m1  = div_m1;
      live_cfg.hs_pol  = hs_pol;
      live_cfg.vs_pol  = vs_pol;
      live_cfg.hsw     = h_sync_m1;
      live_cfg.hbp     = h_back_m1;
      live_cfg.hact    = h_act_m1;
      live_cfg.hfp     = h_front_m1;
      live_cfg.vsw     = v_sync_m1;
      live_cfg.vbp     = v_back_m1;
      live_cfg.vact    = v_act_m1;
      live_cfg.vfp     = v_front_m1;
   end

   // Frame boundary: any idle cycle, or the last source cycle of a frame.
   assign frm_last = running && pix_ce && h_end && v_end;
   assign bnd      = !running || frm_last;
   assign frm_ev   = bnd && vid_en;

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         running        <= 1'b0;
         act_cfg        <= '0;
         act_cfg.hs_pol <= 1'b1;
         act_cfg.vs_pol <= 1'b1;
      end else if (bnd) begin
         running <= vid_en;
         act_cfg <= live_cfg;
      end
   end

   assign act_hs_pol = act_cfg.hs_pol;
   assign act_vs_pol = act_cfg.vs_pol;

   dtg_pix_div #(
      .DIV_W   (DIV_W),
      .HAS_DIV (HAS_DIV)
   ) u_div (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .restart (bnd),
      .run     (running),
      .div_sel (act_cfg.div_sel),
      .div_m1  (act_cfg.div_m1),
      .pix_ce  (pix_ce)
   );

   assign h_step = running && pix_ce;
   assign v_step = h_step && h_end;

   dtg_axis #(.W(H_W)) u_hax (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .restart (bnd),
      .step    (h_step),
      .sw_m1   (act_cfg.hsw),
      .bp_m1   (act_cfg.hbp),
      .act_m1  (act_cfg.hact),
      .fp_m1   (act_cfg.hfp),
      .phase   (h_phase),
      .cnt     (h_cnt),
      .at_end  (h_end)
   );

   dtg_axis #(.W(V_W)) u_vax (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .restart (bnd),
      .step    (v_step),
      .sw_m1   (act_cfg.vsw),
      .bp_m1   (act_cfg.vbp),
      .act_m1  (act_cfg.vact),
      .fp_m1   (act_cfg.vfp),
      .phase   (v_phase),
      .cnt     (v_cnt),
      .at_end  (v_end)
   );

   assign in_act = running && (h_phase == PH_ACT) && (v_phase == PH_ACT);
   assign de     = in_act;
   assign pix_x  = in_act ? h_cnt : '0;
   assign pix_y  = in_act ? v_cnt : '0;
   assign hsync  = drive_level(running && (h_phase == PH_SYNC), act_cfg.hs_pol);
   assign vsync  = drive_level(running && (v_phase == PH_SYNC), act_cfg.vs_pol);

   assign irq_set = frm_ev && irq_glb_en && irq_frm_en;

   dtg_irq u_irq (
      .clk   (clk_src),
      .rst_n (rst_n),
      .set   (irq_set),
      .clr   (irq_clr),
      .pend  (irq)
   );

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
   parameter int H_W = 12,
   parameter int V_W = 11
) (
   input logic           clk,
   input logic           rst_n,
   input logic           de,
   input logic           hsync,
   input logic           vsync,
   input logic [H_W-1:0] pix_x,
   input logic [V_W-1:0] pix_y,
   input logic           irq,
   input logic           irq_clr,
   input logic           frm_ev,
   input logic           irq_set,
   input logic           hs_pol_act,
   input logic           vs_pol_act
);

   AST_DE_OFF_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (hsync != hs_pol_act) && (vsync != vs_pol_act)); // R2

   AST_X_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (de && $past(de) && (pix_y == $past(pix_y)))
      |-> ((pix_x == $past(pix_x)) || (pix_x == $past(pix_x) + 1'b1))); // R4

   AST_FRAME_OPENS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      frm_ev |=> (hsync == hs_pol_act) && (vsync == vs_pol_act)); // R8

   AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> irq); // R10

   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !irq_set) |=> !irq); // R11

   AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq); // R11

endmodule

bind dtg_top dtg_checker #(
   .H_W (H_W),
   .V_W (V_W)
) u_chk (
   .clk        (clk_src),
   .rst_n      (rst_n),
   .de         (de),
   .hsync      (hsync),
   .vsync      (vsync),
   .pix_x      (pix_x),
   .pix_y      (pix_y),
   .irq        (irq),
   .irq_clr    (irq_clr),
   .frm_ev     (frm_ev),
   .irq_set    (irq_set),
   .hs_pol_act (act_hs_pol),
   .vs_pol_act (act_vs_pol)
);

// File: tb/dtg_top_tb.sv
module dtg_top_tb;

   localparam int CLK_P = 10;
   localparam int H_W   = 12;
   localparam int V_W   = 11;
   localparam int DIV_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             vid_en = 1'b0;
   logic             div_sel = 1'b0;
   logic [DIV_W-1:0] div_m1 = '0;
   logic             hs_pol = 1'b1;
   logic             vs_pol = 1'b1;
   logic [H_W-1:0]   h_sync_m1 = '0, h_back_m1 = '0, h_act_m1 = '0, h_front_m1 = '0;
   logic [V_W-1:0]   v_sync_m1 = '0, v_back_m1 = '0, v_act_m1 = '0, v_front_m1 = '0;
   logic             irq_glb_en = 1'b0, irq_frm_en = 1'b0, irq_clr = 1'b0;
   logic             hsync, vsync, de, irq;
   logic [H_W-1:0]   pix_x;
   logic [V_W-1:0]   pix_y;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   dtg_top #(.H_W(H_W), .V_W(V_W), .DIV_W(DIV_W)) u_dut (
      .clk_src(clk), .rst_n(rst_n), .vid_en(vid_en), .div_sel(div_sel), .div_m1(div_m1),
      .hs_pol(hs_pol), .vs_pol(vs_pol),
      .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1), .h_act_m1(h_act_m1), .h_front_m1(h_front_m1),
      .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1), .v_act_m1(v_act_m1), .v_front_m1(v_front_m1),
      .irq_glb_en(irq_glb_en), .irq_frm_en(irq_frm_en), .irq_clr(irq_clr),
      .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input int got, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s got %0d exp %0d at %0t", tag, got, exp, $time);
      end
   endtask

   // ---------------- reference model (frame arithmetic) ----------------
   bit m_run = 0, m_pend = 0, m_hp = 1, m_vp = 1;
   int m_t = 0, m_ratio = 1;
   int m_hsw = 1, m_hbp = 1, m_hact = 1, m_hfp = 1;
   int m_vsw = 1, m_vbp = 1, m_vact = 1, m_vfp = 1;

   always @(negedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_pend = 0; m_hp = 1; m_vp = 1; m_t = 0; m_ratio = 1;
         m_hsw = 1; m_hbp = 1; m_hact = 1; m_hfp = 1;
         m_vsw = 1; m_vbp = 1; m_vact = 1; m_vfp = 1;
      end else begin
         bit e_hs, e_vs, e_de, ok, bnd;
         int e_x, e_y, p, h, l, htot, vtot, hs0, vs0;
         htot = m_hsw + m_hbp + m_hact + m_hfp;
         vtot = m_vsw + m_vbp + m_vact + m_vfp;
         hs0  = m_hsw + m_hbp;
         vs0  = m_vsw + m_vbp;
         if (!m_run) begin
            e_hs = !m_hp; e_vs = !m_vp; e_de = 0; e_x = 0; e_y = 0;
         end else begin
            p = m_t / m_ratio;
            h = p % htot;
            l = p / htot;
            e_hs = (h < m_hsw) ? m_hp : !m_hp;
            e_vs = (l < m_vsw) ? m_vp : !m_vp;
            e_de = (h >= hs0) && (h < hs0 + m_hact) && (l >= vs0) && (l < vs0 + m_vact);
            e_x  = e_de ? h - hs0 : 0;
            e_y  = e_de ? l - vs0 : 0;
         end
         ok = (hsync === e_hs) && (vsync === e_vs) && (de === e_de) &&
              (int'(pix_x) == e_x) && (int'(pix_y) == e_y) && (irq === m_pend);
         if (hsync !== e_hs)           chk(ok, "R2 hsync", int'(hsync), int'(e_hs));
         else if (vsync !== e_vs)      chk(ok, "R3 vsync", int'(vsync), int'(e_vs));
         else if (de !== e_de)         chk(ok, "R4 de", int'(de), int'(e_de));
         else if (int'(pix_x) != e_x)  chk(ok, "R4 pix_x", int'(pix_x), e_x);
         else if (int'(pix_y) != e_y)  chk(ok, "R4 pix_y", int'(pix_y), e_y);
         else                          chk(ok, "R10 irq", int'(irq), int'(m_pend));
         // advance the model across the coming clock edge
         bnd = !m_run || (m_t == htot * vtot * m_ratio - 1);
         if (bnd) begin
            m_hsw = int'(h_sync_m1) + 1; m_hbp = int'(h_back_m1) + 1;
            m_hact = int'(h_act_m1) + 1; m_hfp = int'(h_front_m1) + 1;
            m_vsw = int'(v_sync_m1) + 1; m_vbp = int'(v_back_m1) + 1;
            m_vact = int'(v_act_m1) + 1; m_vfp = int'(v_front_m1) + 1;
            m_ratio = div_sel ? int'(div_m1) + 1 : 1;
            m_hp = hs_pol; m_vp = vs_pol;
            m_run = vid_en; m_t = 0;
            if (vid_en && irq_glb_en && irq_frm_en) m_pend = 1;
            else if (irq_clr) m_pend = 0;
         end else begin
            m_t++;
            if (irq_clr) m_pend = 0;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic at_edge();
      @(posedge clk); #1;
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_vs_start(input bit lvl);
      bit prev;
      prev = vsync;
      forever begin
         @(negedge clk);
         if (vsync == lvl && prev != lvl) break;
         prev = vsync;
      end
   endtask

   task automatic run_len(input bit lvl, output int n);
      n = 0;
      while (hsync == lvl) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic rand_cfg();
      h_sync_m1  = H_W'($urandom_range(0, 2));
      h_back_m1  = H_W'($urandom_range(0, 2));
      h_act_m1   = H_W'($urandom_range(0, 5));
      h_front_m1 = H_W'($urandom_range(0, 2));
      v_sync_m1  = V_W'($urandom_range(0, 1));
      v_back_m1  = V_W'($urandom_range(0, 1));
      v_act_m1   = V_W'($urandom_range(0, 3));
      v_front_m1 = V_W'($urandom_range(0, 1));
      div_sel    = 1'($urandom_range(0, 1));
      div_m1     = DIV_W'($urandom_range(0, 3));
      hs_pol     = 1'($urandom_range(0, 1));
      vs_pol     = 1'($urandom_range(0, 1));
   endtask

   initial begin
      #(CLK_P * 195000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'd20240611));
      wait_neg(4);
      at_edge(); rst_n = 1'b1;
      @(negedge clk);
      // R1: idle after reset
      chk(hsync == 1'b0 && vsync == 1'b0, "R1 sync idle", int'({hsync, vsync}), 0);
      chk(de == 1'b0 && pix_x == '0 && pix_y == '0, "R1 de/xy", int'(de), 0);
      chk(irq == 1'b0, "R1 irq", int'(irq), 0);

      // Directed start: line 2+1+4+1=8 px, frame 1+1+2+1=5 lines
      at_edge();
      h_sync_m1 = 1; h_back_m1 = 0; h_act_m1 = 3; h_front_m1 = 0;
      v_sync_m1 = 0; v_back_m1 = 0; v_act_m1 = 1; v_front_m1 = 0;
      div_sel = 0; div_m1 = 5; hs_pol = 0; vs_pol = 1;
      irq_glb_en = 1; irq_frm_en = 1; vid_en = 1;
      wait_neg(2);
      chk(vsync == 1'b1, "R8 vsync active at start", int'(vsync), 1);
      chk(hsync == 1'b0, "R5 hsync active-low at start", int'(hsync), 0);
      chk(irq == 1'b1, "R10 irq raised at frame start", int'(irq), 1);
      run_len(1'b0, n);
      chk(n == 2, "R6 bypass ignores div_m1", n, 2);

      // R11: clear pulse
      at_edge(); irq_clr = 1;
      at_edge(); irq_clr = 0;
      @(negedge clk);
      chk(irq == 1'b0, "R11 clear drops pending", int'(irq), 0);

      // R10: frame interrupt disabled
      at_edge(); irq_frm_en = 0;
      wait_vs_start(1'b1);
      chk(irq == 1'b0, "R10 gated by frame enable", int'(irq), 0);

      // R7: divider change mid-frame, seen only from next frame
      at_edge(); div_sel = 1; div_m1 = 2;
      while (hsync == 1'b0) @(negedge clk);
      while (hsync == 1'b1) @(negedge clk);
      run_len(1'b0, n);
      chk(n == 2, "R7 mid-frame divider change deferred", n, 2);
      wait_vs_start(1'b1);
      run_len(1'b0, n);
      chk(n == 6, "R6 divided sync width", n, 6);

      // R9: stop mid-frame, frame of 120 cycles completes
      wait_vs_start(1'b1);
      at_edge(); vid_en = 0;
      n = 0;
      for (int i = 1; i < 120; i++) begin
         @(negedge clk);
         if (de) n++;
      end
      chk(n == 24, "R9 frame completes after stop", n, 24);
      n = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (de || vsync || !hsync) n++;
      end
      chk(n == 0, "R9 outputs idle after stop", n, 0);

      // Random scenarios
      for (int s = 0; s < 12; s++) begin
         at_edge();
         rand_cfg();
         vid_en = 1;
         irq_glb_en = 1'($urandom_range(0, 1));
         irq_frm_en = 1'($urandom_range(0, 1));
         for (int c = 0; c < 1400; c++) begin
            at_edge();
            irq_clr = ($urandom_range(0, 7) == 0);
            if (c == 600 + int'($urandom_range(0, 50))) rand_cfg();
            if (c == 900) begin
               irq_glb_en = 1'($urandom_range(0, 1));
               irq_frm_en = 1'($urandom_range(0, 1));
            end
         end
         at_edge(); vid_en = 0; irq_clr = 0;
         wait_neg(700);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule